// File: doc/BRIEF.md
# Floating-Point Stack Register Renamer

This block keeps the alias table for an eight-deep floating-point register stack whose instructions name their operands by distance from a moving top of stack. Each stack position ST(i) is mapped to a physical register tag. Pushes, pops and double pops move a wrapping top pointer and take tags from, or return tags to, a pool of free tags. An exchange of ST(0) with ST(i) swaps two alias entries and nothing else. No data is moved and no execution operation is produced.

In each cycle the front end may present one stack operation (push, pop, double pop, or a compute that writes a fresh result to ST(0)) together with an optional exchange. The whole bundle is resolved in that cycle, and the exchange is applied after the stack adjustment made by the operation. The block returns the physical tags of the implicit source operands and the tag granted to a new destination. It raises overflow, underflow or stall when the bundle cannot be taken, and in that case it discards the whole bundle. Source tags are read from the mapping as it stood before the cycle's update, so an instruction in flight keeps using an old tag while the position is renamed.

Top module: `stack_rename`

## Requirements
- R1: After reset every position is invalid and every physical tag is free, so a compute or pop raises underflow and the first accepted push is granted tag 0.
- R2: An accepted push (op_kind 1) maps the new ST(0) to the lowest-numbered free tag, shown on dst_tag in that cycle, and the old ST(i) becomes ST(i+1).
- R3: An accepted pop (op_kind 2) returns the tag of ST(0) to the pool and the old ST(i+1) becomes ST(i). An accepted double pop (op_kind 3) returns the tags of ST(0) and ST(1) and shifts the stack by two.
- R4: An accepted compute (op_kind 0) reads ST(0) on src_a_tag and ST(op_idx) on src_b_tag. It maps ST(0) to the lowest free tag, shown on dst_tag, and returns the tag that ST(0) held before.
- R5: An exchange given without an operation swaps the tags of ST(0) and ST(xch_idx). It takes no tag and releases none.
- R6: An exchange paired with an operation acts on the positions as they stand after that operation's stack adjustment, and both take effect at the same clock edge.
- R7: A push while ST(7) is valid raises overflow in that cycle and the whole bundle leaves the mapping and the pool unchanged.
- R8: Underflow is raised, and the whole bundle is discarded, when a pop finds ST(0) invalid, a double pop finds ST(0) or ST(1) invalid, a compute finds ST(0) or ST(op_idx) invalid, or an exchange finds either of its two positions invalid after the adjustment.
- R9: A push or compute that finds no free tag and raises no fault asserts stall and changes nothing. Overflow and underflow take priority over stall.
- R10: A tag returned by an accepted bundle can be granted again from the next cycle on, in lowest-first order.
- R11: src_a_tag and src_b_tag (src_b_tag is ST(1) for a double pop) show the mapping held before the cycle's update, and an exchange never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A stack operation is presented this cycle |
| op_kind | input | 2 | 0 compute, 1 push, 2 pop, 3 double pop |
| op_idx | input | POS_W | Stack distance of the second compute operand |
| xch_valid | input | 1 | An exchange is presented this cycle |
| xch_idx | input | POS_W | Stack distance swapped with ST(0) |
| accept | output | 1 | The bundle is taken at the next edge |
| stall | output | 1 | The bundle waits because no tag is free |
| overflow | output | 1 | Push onto a full stack |
| underflow | output | 1 | Operation or exchange touches an empty position |
| src_a_tag | output | TAG_W | Tag of ST(0) before the update |
| src_b_tag | output | TAG_W | Tag of ST(op_idx), or ST(1) for a double pop |
| dst_tag | output | TAG_W | Tag granted to the new ST(0) |

## Verification
The checker watches every cycle for several properties. The count of free tags plus the count of occupied positions must always equal the tag total. Fault and stall cycles must freeze both the pool and the valid map. An exchange without an operation must touch neither. A granted tag must have been free, and an accepted push must grow occupancy by exactly one. Which tag ends up at which stack distance is left to the bench's scenarios, compared against an independent shifting-stack model: the ordering of a paired exchange after a push or double pop, the lowest-first reuse of returned tags, and the old-mapping reads.

// File: rtl/srn_pkg.sv
package srn_pkg;
    typedef enum logic [1:0] {
        OP_CALC = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_POP2 = 2'd3
    } stk_op_e;
endpackage

// File: rtl/srn_tag_pick.sv
module srn_tag_pick #(
    parameter int N = 12,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] free_vec,
    output logic         found,
    output logic [W-1:0] idx
);
    // lowest set bit wins: scan downward so the last hit is the smallest index
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/srn_free_pool.sv
module srn_free_pool #(
    parameter int TAG_CNT = 12,
    parameter int TAG_W   = $clog2(TAG_CNT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [TAG_CNT-1:0] release_mask,
    output logic [TAG_CNT-1:0] free_vec,
    output logic               avail,
    output logic [TAG_W-1:0]   pick
);
    typedef struct packed {
        logic [TAG_CNT-1:0] free;
    } pool_t;

    pool_t st_q, st_d;

    srn_tag_pick #(.N(TAG_CNT), .W(TAG_W)) pick_i (
        .free_vec (st_q.free),
        .found    (avail),
        .idx      (pick)
    );

    // a returned tag was not free this cycle, so it never collides with pick
    always_comb begin
        st_d      = st_q;
        st_d.free = st_q.free | release_mask;
        if (take) begin
            st_d.free[pick] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.free <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign free_vec = st_q.free;
endmodule

// File: rtl/srn_alias_table.sv
module srn_alias_table
    import srn_pkg::*;
#(
    parameter int POS_CNT = 8,
    parameter int POS_W   = $clog2(POS_CNT),
    parameter int TAG_W   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            commit,
    input  logic                            op_en,
    input  stk_op_e                         op,
    input  logic [TAG_W-1:0]                new_tag,
    input  logic                            xch_en,
    input  logic [POS_W-1:0]                xch_idx,
    output logic [POS_W-1:0]                top,
    output logic [POS_CNT-1:0]              vld,
    output logic [POS_CNT-1:0][TAG_W-1:0]   tag_map,
    output logic                            xch_ok
);
    typedef struct packed {
        logic [POS_W-1:0]              top;
        logic [POS_CNT-1:0]            vld;
        logic [POS_CNT-1:0][TAG_W-1:0] tag;
    } tbl_t;

    tbl_t st_q, st_d;
    tbl_t post;
    tbl_t swapped;
    logic [POS_W-1:0] t_dn, t_up1, t_up2;
    logic [POS_W-1:0] xa, xb;

    always_comb begin
        t_dn  = st_q.top - POS_W'(1);
        t_up1 = st_q.top + POS_W'(1);
        t_up2 = st_q.top + POS_W'(2);

        // stage 1: stack adjustment of the operation
        post = st_q;
        if (op_en) begin
            case (op)
                OP_PUSH: begin
                    post.top        = t_dn;
                    post.vld[t_dn]  = 1'b1;
                    post.tag[t_dn]  = new_tag;
                end
                OP_POP: begin
                    post.vld[st_q.top] = 1'b0;
                    post.top           = t_up1;
                end
                OP_POP2: begin
                    post.vld[st_q.top] = 1'b0;
                    post.vld[t_up1]    = 1'b0;
                    post.top           = t_up2;
                end
                OP_CALC: begin
                    post.tag[st_q.top] = new_tag;
                end
            endcase
        end

        // stage 2: exchange on the adjusted stack
        xa     = post.top;
        xb     = post.top + xch_idx;
        xch_ok = post.vld[xa] & post.vld[xb];

        swapped = post;
        if (xch_en) begin
            swapped.tag[xa] = post.tag[xb];
            swapped.tag[xb] = post.tag[xa];
        end

        st_d = commit ? swapped : st_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.top <= '0;
            st_q.vld <= '0;
            st_q.tag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top     = st_q.top;
    assign vld     = st_q.vld;
    assign tag_map = st_q.tag;
endmodule

// File: rtl/stack_rename.sv
module stack_rename
    import srn_pkg::*;
#(
    parameter int POS_CNT = 8,
    parameter int TAG_CNT = 12,
    localparam int POS_W  = $clog2(POS_CNT),
    localparam int TAG_W  = $clog2(TAG_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic [POS_W-1:0] op_idx,
    input  logic             xch_valid,
    input  logic [POS_W-1:0] xch_idx,
    output logic             accept,
    output logic             stall,
    output logic             overflow,
    output logic             underflow,
    output logic [TAG_W-1:0] src_a_tag,
    output logic [TAG_W-1:0] src_b_tag,
    output logic [TAG_W-1:0] dst_tag
);
    typedef struct packed {
        logic               ovf;
        logic               unf;
        logic               stall;
        logic               acc;
        logic               take;
        logic [TAG_CNT-1:0] rel;
    } ctl_t;

    stk_op_e                       kind;
    ctl_t                          ctl;
    logic [POS_W-1:0]              tbl_top;
    logic [POS_CNT-1:0]            tbl_vld;
    logic [POS_CNT-1:0][TAG_W-1:0] tbl_tag;
    logic                          tbl_xch_ok;
    logic [TAG_CNT-1:0]            pool_free;
    logic                          pool_avail;
    logic [TAG_W-1:0]              pool_pick;
    logic [POS_W-1:0]              s0, s1, sb, s_last, b_idx;
    logic                          is_push, is_pop, is_pop2, is_calc, needs_tag, unf_op, unf_x;

    assign kind = stk_op_e'(op_kind);

    always_comb begin
        is_push   = op_valid && (kind == OP_PUSH);
        is_pop    = op_valid && (kind == OP_POP);
        is_pop2   = op_valid && (kind == OP_POP2);
        is_calc   = op_valid && (kind == OP_CALC);
        needs_tag = is_push || is_calc;

        b_idx  = (kind == OP_POP2) ? POS_W'(1) : op_idx;
        s0     = tbl_top;
        s1     = tbl_top + POS_W'(1);
        sb     = tbl_top + b_idx;
        s_last = tbl_top - POS_W'(1);

        unf_op = (is_pop  && !tbl_vld[s0])
              || (is_pop2 && !(tbl_vld[s0] && tbl_vld[s1]))
              || (is_calc && !(tbl_vld[s0] && tbl_vld[sb]));
        unf_x  = xch_valid && !tbl_xch_ok;

        ctl       = '0;
        ctl.ovf   = is_push && tbl_vld[s_last];
        ctl.unf   = unf_op || unf_x;
        ctl.stall = needs_tag && !pool_avail && !ctl.ovf && !ctl.unf;
        ctl.acc   = (op_valid || xch_valid) && !ctl.ovf && !ctl.unf && !ctl.stall;
        ctl.take  = ctl.acc && needs_tag;

        if (ctl.acc && (is_pop || is_pop2 || is_calc)) begin
            ctl.rel[tbl_tag[s0]] = 1'b1;
        end
        if (ctl.acc && is_pop2) begin
            ctl.rel[tbl_tag[s1]] = 1'b1;
        end
    end

    srn_free_pool #(.TAG_CNT(TAG_CNT), .TAG_W(TAG_W)) pool_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (ctl.take),
        .release_mask (ctl.rel),
        .free_vec     (pool_free),
        .avail        (pool_avail),
        .pick         (pool_pick)
    );

    srn_alias_table #(.POS_CNT(POS_CNT), .POS_W(POS_W), .TAG_W(TAG_W)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (ctl.acc),
        .op_en    (op_valid),
        .op       (kind),
        .new_tag  (pool_pick),
        .xch_en   (xch_valid),
        .xch_idx  (xch_idx),
        .top      (tbl_top),
        .vld      (tbl_vld),
        .tag_map  (tbl_tag),
        .xch_ok   (tbl_xch_ok)
    );

    assign accept    = ctl.acc;
    assign stall     = ctl.stall;
    assign overflow  = ctl.ovf;
    assign underflow = ctl.unf;
    assign src_a_tag = tbl_tag[s0];
    assign src_b_tag = tbl_tag[sb];
    assign dst_tag   = pool_pick;
endmodule

// File: rtl/srn_checker.sv
module srn_checker #(
    parameter int POS_CNT = 8,
    parameter int TAG_CNT = 12,
    localparam int TAG_W  = $clog2(TAG_CNT)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [1:0]         op_kind,
    input logic               xch_valid,
    input logic               accept,
    input logic               stall,
    input logic               overflow,
    input logic               underflow,
    input logic [TAG_W-1:0]   dst_tag,
    input logic [TAG_CNT-1:0] free_vec,
    input logic [POS_CNT-1:0] vld_vec
);
    AST_TAG_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(free_vec) + $countones(vld_vec)) == TAG_CNT); // R3

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_valid && op_kind == 2'd1)
        |=> $countones(vld_vec) == $past($countones(vld_vec)) + 1); // R2

    AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> ($stable(free_vec) && $stable(vld_vec))); // R7

    AST_UNF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> ($stable(free_vec) && $stable(vld_vec))); // R8

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(free_vec) && $stable(vld_vec))); // R9

    AST_STALL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!overflow && !underflow && !accept)); // R9

    AST_XCH_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !op_valid && xch_valid)
        |=> ($stable(free_vec) && $stable(vld_vec))); // R5

    AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_valid && (op_kind == 2'd0 || op_kind == 2'd1))
        |-> free_vec[dst_tag]); // R10
endmodule

bind stack_rename srn_checker #(.POS_CNT(POS_CNT), .TAG_CNT(TAG_CNT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .xch_valid (xch_valid),
    .accept    (accept),
    .stall     (stall),
    .overflow  (overflow),
    .underflow (underflow),
    .dst_tag   (dst_tag),
    .free_vec  (pool_free),
    .vld_vec   (tbl_vld)
);

// File: tb/stack_rename_tb_top.sv
module stack_rename_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int POS  = 8;
    localparam int TAGS = 8;
    localparam int PW   = $clog2(POS);
    localparam int TW   = $clog2(TAGS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic [PW-1:0] op_idx = '0;
    logic xch_valid = 1'b0;
    logic [PW-1:0] xch_idx = '0;
    logic accept, stall, overflow, underflow;
    logic [TW-1:0] src_a_tag, src_b_tag, dst_tag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stack_rename #(.POS_CNT(POS), .TAG_CNT(TAGS)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_idx(op_idx),
        .xch_valid(xch_valid), .xch_idx(xch_idx), .accept(accept), .stall(stall),
        .overflow(overflow), .underflow(underflow), .src_a_tag(src_a_tag),
        .src_b_tag(src_b_tag), .dst_tag(dst_tag)
    );

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    // shifting-stack model: index 0 is ST(0)
    int m_tag [POS];
    bit m_vld [POS];
    bit m_free [TAGS];

    int s_src_a, s_src_b, s_dst, s_stall, s_ovf, s_unf;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int t = 0; t < TAGS; t++) if (m_free[t]) return t;
        return -1;
    endfunction

    task automatic step(input string lbl, input bit ov, input int kind, input int idx,
                        input bit xv, input int xi);
        int t_tag [POS];
        bit t_vld [POS];
        int lf, b, tmp;
        bit need, e_ovf, e_uo, e_ux, e_unf, e_stall, e_acc;
        @(negedge clk);
        op_valid = ov; op_kind = 2'(kind); op_idx = PW'(idx);
        xch_valid = xv; xch_idx = PW'(xi);
        #1;
        s_src_a = int'(src_a_tag); s_src_b = int'(src_b_tag); s_dst = int'(dst_tag);
        s_stall = int'(stall); s_ovf = int'(overflow); s_unf = int'(underflow);

        need  = ov && (kind == 0 || kind == 1);
        e_ovf = ov && kind == 1 && m_vld[POS-1];
        e_uo  = ov && ((kind == 2 && !m_vld[0]) ||
                       (kind == 3 && !(m_vld[0] && m_vld[1])) ||
                       (kind == 0 && !(m_vld[0] && m_vld[idx])));
        lf = lowest_free();
        for (int i = 0; i < POS; i++) begin t_tag[i] = m_tag[i]; t_vld[i] = m_vld[i]; end
        if (ov) begin
            case (kind)
                1: begin
                    for (int i = POS - 1; i > 0; i--) begin t_tag[i] = m_tag[i-1]; t_vld[i] = m_vld[i-1]; end
                    t_tag[0] = lf; t_vld[0] = 1'b1;
                end
                2: begin
                    for (int i = 0; i < POS - 1; i++) begin t_tag[i] = m_tag[i+1]; t_vld[i] = m_vld[i+1]; end
                    t_vld[POS-1] = 1'b0;
                end
                3: begin
                    for (int i = 0; i < POS - 2; i++) begin t_tag[i] = m_tag[i+2]; t_vld[i] = m_vld[i+2]; end
                    t_vld[POS-2] = 1'b0; t_vld[POS-1] = 1'b0;
                end
                default: t_tag[0] = lf;
            endcase
        end
        e_ux    = xv && !(t_vld[0] && t_vld[xi]);
        e_unf   = e_uo || e_ux;
        e_stall = need && lf < 0 && !e_ovf && !e_unf;
        e_acc   = (ov || xv) && !e_ovf && !e_unf && !e_stall;

        chk("R7", s_ovf, int'(e_ovf));
        chk("R8", s_unf, int'(e_unf));
        chk("R9", s_stall, int'(e_stall));
        chk(lbl, int'(accept), int'(e_acc));
        if (ov && kind != 1 && m_vld[0]) chk("R11", s_src_a, m_tag[0]);
        b = (kind == 3) ? 1 : idx;
        if (ov && (kind == 0 || kind == 3) && m_vld[b]) chk("R11", s_src_b, m_tag[b]);
        if (need && lf >= 0) chk(kind == 1 ? "R2" : "R4", s_dst, lf);

        @(posedge clk);
        if (e_acc) begin
            if (need) m_free[lf] = 1'b0;
            if (ov && kind != 1) m_free[m_tag[0]] = 1'b1;
            if (ov && kind == 3) m_free[m_tag[1]] = 1'b1;
            if (xv) begin tmp = t_tag[0]; t_tag[0] = t_tag[xi]; t_tag[xi] = tmp; end
            for (int i = 0; i < POS; i++) begin m_tag[i] = t_tag[i]; m_vld[i] = t_vld[i]; end
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned rs;
        for (int i = 0; i < POS; i++) begin m_tag[i] = 0; m_vld[i] = 1'b0; end
        for (int t = 0; t < TAGS; t++) m_free[t] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset
        step("R1", 1'b0, 0, 0, 1'b0, 0);
        step("R1", 1'b1, 0, 0, 1'b0, 0);
        chk("R1", s_unf, 1);
        step("R1", 1'b1, 2, 0, 1'b0, 0);
        step("R1", 1'b1, 1, 0, 1'b0, 0);
        chk("R1", s_dst, 0);
        step("R2", 1'b1, 1, 0, 1'b0, 0);
        step("R2", 1'b1, 1, 0, 1'b0, 0);
        chk("R2", s_dst, 2);

        // R5: lone exchange, then read back through a compute
        step("R5", 1'b0, 0, 0, 1'b1, 2);
        step("R5", 1'b1, 0, 2, 1'b0, 0);
        chk("R5", s_src_a, 0);
        chk("R5", s_src_b, 2);

        // R6: push paired with exchange
        step("R6", 1'b1, 1, 0, 1'b1, 1);
        step("R6", 1'b1, 0, 1, 1'b0, 0);
        chk("R6", s_src_a, 3);
        chk("R6", s_src_b, 0);

        // R6: double pop paired with exchange
        step("R6", 1'b1, 3, 0, 1'b1, 1);
        step("R6", 1'b1, 0, 1, 1'b0, 0);
        chk("R6", s_src_a, 2);
        chk("R6", s_src_b, 1);

        // R10: returned tag granted again
        step("R10", 1'b1, 2, 0, 1'b0, 0);
        step("R10", 1'b1, 1, 0, 1'b0, 0);
        chk("R10", s_dst, 0);

        // fill the stack, then overflow and stall
        for (int k = 0; k < 6; k++) step("R2", 1'b1, 1, 0, 1'b0, 0);
        step("R7", 1'b1, 1, 0, 1'b0, 0);
        chk("R7", s_ovf, 1);
        step("R9", 1'b1, 0, 0, 1'b0, 0);
        chk("R9", s_stall, 1);
        step("R3", 1'b1, 2, 0, 1'b0, 0);
        step("R8", 1'b0, 0, 0, 1'b1, 7);
        chk("R8", s_unf, 1);
        step("R3", 1'b1, 1, 0, 1'b0, 0);
        chk("R3", s_dst, 7);

        // near-exhaustive sweep of bundles against the model
        rs = 32'h1ACE_5EED;
        for (int n = 0; n < 6000; n++) begin
            int k, kind;
            rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
            k = int'(rs % 8);
            kind = (k < 3) ? 1 : (k == 3) ? 2 : (k == 4) ? 3 : 0;
            step("R11", ((rs >> 3) % 8) != 0, kind, int'((rs >> 6) % 8),
                 ((rs >> 9) & 1) != 0, int'((rs >> 10) % 8));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule